// File: doc/BRIEF.md
# Pin-or-Register Output Selector with Latched Side Output

This block drives five selectable outputs and one side output. Each selectable output takes its value either from a matching external input pin or from one bit of a 6-bit stored configuration word. The side output always takes its value from the remaining bit of that word, through a latch of its own. Every output is presented as an open-drain pull-down enable. The pad drives low when the logical output value is 0.

After reset, an external select pin chooses the source. The pin is brought into the clock domain through two flops. A write to a 2-bit control register can take over the choice. Bit 0 hands selection to the register, and bit 1 then chooses the source. A force-low input clears the selectable outputs whenever they are sourced from the stored word. When the storage reports that it is being reprogrammed, outputs sourced from the stored word keep their old values until the flag drops. In register mode, the side output is captured at the slave-acknowledge pulse that follows a write raising bit 1.

Top module: `oml_outmux`

## Requirements
- R1: Reset clears the control register to 0, which selects pin mode. A register write made before reset has no effect after it.
- R2: In pin mode with the synchronized select pin low, selectable output i carries stored bit i (bits 4:0), and the side output carries stored bit 5.
- R3: In pin mode with the synchronized select pin high, selectable output i carries external input i.
- R4: In pin mode, the side output follows stored bit 5 while the select pin is low. It holds the value present in the last cycle before the synchronized pin rose, and later changes to the stored word do not alter it.
- R5: A control write with bit 0 = 1 puts the block in register mode. In that mode the select pin has no effect on any output.
- R6: In register mode, control bit 1 = 1 sources the selectable outputs from the stored word, and bit 1 = 0 sources them from the external inputs.
- R7: In register mode, the side output loads stored bit 5 on the first slave-acknowledge pulse after a control write that changes bit 1 from 0 to 1. It ignores acknowledge pulses that are not armed in this way.
- R8: When the force-low input is 0 and the selectable outputs are sourced from the stored word, all selectable outputs are 0. When they are sourced from the external inputs, the force-low input has no effect.
- R9: While the program-busy flag is 1, outputs sourced from the stored word keep the values of the last cycle before the flag rose. They take the new word once the flag returns to 0.
- R10: Each pull-down enable is the inverse of its logical output value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_pin | input | 1 | Asynchronous source select pin (low = stored word) |
| hold_low_n | input | 1 | Force-low control, active at 0 |
| ext_in | input | 5 | External inputs for the selectable outputs |
| cfg_word | input | 6 | Stored configuration word |
| prog_busy | input | 1 | Storage reprogramming in progress |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 2 | Control write data: bit 0 register mode, bit 1 register select |
| slave_ack | input | 1 | Acknowledge pulse from the serial-bus slave |
| mux_pd | output | 5 | Pull-down enables of the selectable outputs |
| solo_pd | output | 1 | Pull-down enable of the side output |

## Verification
The external inputs, the stored word, the force-low input and the busy flag act on the outputs in the same cycle, through logic alone. A change on the select pin needs two clock edges to pass the synchronizer. A control write or an acknowledge pulse shows at the outputs after the clock edge that samples it. After every stimulus, the bench drives at the falling edge and waits three rising edges before sampling. It samples a quarter period after the last rising edge, so the longest path, the select pin, has settled. Hold behaviour is checked by changing the stored word after the capture point and confirming that the output has not moved.

// File: rtl/oml_pkg.sv
package oml_pkg;

    localparam int MUX_W_DEF  = 5;
    localparam int SYNC_N_DEF = 2;

    typedef struct packed {
        logic sel_bit;
        logic reg_mode;
    } ctrl_t;

    typedef enum logic { SRC_PINS = 1'b0, SRC_WORD = 1'b1 } src_e;

    function automatic src_e pick_src(ctrl_t c, logic pin_sync);
        if (c.reg_mode) return c.sel_bit ? SRC_WORD : SRC_PINS;
        return pin_sync ? SRC_PINS : SRC_WORD;
    endfunction

endpackage

// File: rtl/oml_sync.sv
module oml_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= 1'b0;
            else if (s == 0) chain[s] <= d;
            else chain[s] <= chain[(s == 0) ? 0 : s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/oml_word_hold.sv
module oml_word_hold #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         busy,
    input  logic [W-1:0] word_in,
    output logic [W-1:0] word_out
);
    logic [W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst) held_q <= '0;
        else if (!busy) held_q <= word_in;
    end

    assign word_out = busy ? held_q : word_in;
endmodule

// File: rtl/oml_solo_latch.sv
module oml_solo_latch (
    input  logic clk,
    input  logic rst,
    input  logic pin_mode,
    input  logic pin_sync,
    input  logic arm,
    input  logic ack,
    input  logic bit_in,
    output logic val
);
    logic latch_q;
    logic pend_q;
    logic open_w;

    assign open_w = pin_mode && !pin_sync;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            if (open_w) latch_q <= bit_in;
            else if (!pin_mode && ack && pend_q) latch_q <= bit_in;

            if (arm) pend_q <= 1'b1;
            else if (ack) pend_q <= 1'b0;
        end
    end

    assign val = open_w ? bit_in : latch_q;
endmodule

// File: rtl/oml_outmux.sv
module oml_outmux
    import oml_pkg::*;
#(
    parameter int MUX_W  = MUX_W_DEF,
    parameter int SYNC_N = SYNC_N_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_pin,
    input  logic             hold_low_n,
    input  logic [MUX_W-1:0] ext_in,
    input  logic [MUX_W:0]   cfg_word,
    input  logic             prog_busy,
    input  logic             ctrl_wr,
    input  logic [1:0]       ctrl_wdata,
    input  logic             slave_ack,
    output logic [MUX_W-1:0] mux_pd,
    output logic             solo_pd
);
    localparam int WORD_W = MUX_W + 1;

    ctrl_t              ctrl_q;
    logic               sel_sync;
    logic [WORD_W-1:0]  eff_word;
    logic               src_word;
    logic               arm_w;
    logic               solo_val;
    logic [MUX_W-1:0]   mux_val;

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= ctrl_t'(ctrl_wdata);
    end

    assign arm_w = ctrl_wr && ctrl_wdata[0] && ctrl_wdata[1] && !ctrl_q.sel_bit;

    oml_sync #(.STAGES(SYNC_N)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (sel_pin),
        .q   (sel_sync)
    );

    oml_word_hold #(.W(WORD_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .busy     (prog_busy),
        .word_in  (cfg_word),
        .word_out (eff_word)
    );

    oml_solo_latch u_solo (
        .clk      (clk),
        .rst      (rst),
        .pin_mode (!ctrl_q.reg_mode),
        .pin_sync (sel_sync),
        .arm      (arm_w),
        .ack      (slave_ack),
        .bit_in   (eff_word[MUX_W]),
        .val      (solo_val)
    );

    assign src_word = (pick_src(ctrl_q, sel_sync) == SRC_WORD);

    for (genvar i = 0; i < MUX_W; i++) begin : g_out
        assign mux_val[i] = src_word ? (hold_low_n && eff_word[i]) : ext_in[i];
    end

    assign mux_pd  = ~mux_val;
    assign solo_pd = ~solo_val;
endmodule

// File: rtl/oml_outmux_chk.sv
module oml_outmux_chk #(
    parameter int MUX_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       ctrl_bits,
    input logic             sel_sync,
    input logic             src_word,
    input logic             hold_low_n,
    input logic             prog_busy,
    input logic             slave_ack,
    input logic [MUX_W-1:0] ext_in,
    input logic [MUX_W:0]   eff_word,
    input logic [MUX_W-1:0] mux_pd,
    input logic             solo_pd
);
    a_r1_reset_pin_mode: assert property (@(posedge clk)
        rst |=> (ctrl_bits == 2'b00));

    a_r6_reg_pins: assert property (@(posedge clk) disable iff (rst)
        (ctrl_bits == 2'b01) |-> (mux_pd == ~ext_in));

    a_r8_force_low: assert property (@(posedge clk) disable iff (rst)
        (src_word && !hold_low_n) |-> (&mux_pd));

    a_r9_busy_hold: assert property (@(posedge clk) disable iff (rst)
        (prog_busy && $past(prog_busy) && src_word && $past(src_word)
         && hold_low_n && $past(hold_low_n)) |-> $stable(mux_pd));

    a_r4_solo_open: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_bits[0] && !sel_sync) |-> (solo_pd == !eff_word[MUX_W]));

    a_r7_solo_ack_only: assert property (@(posedge clk) disable iff (rst)
        (ctrl_bits[0] && $past(ctrl_bits[0]) && !$past(slave_ack)) |-> $stable(solo_pd));
endmodule

bind oml_outmux oml_outmux_chk #(.MUX_W(MUX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctrl_bits  (ctrl_q),
    .sel_sync   (sel_sync),
    .src_word   (src_word),
    .hold_low_n (hold_low_n),
    .prog_busy  (prog_busy),
    .slave_ack  (slave_ack),
    .ext_in     (ext_in),
    .eff_word   (eff_word),
    .mux_pd     (mux_pd),
    .solo_pd    (solo_pd)
);

// File: tb/tb_oml_outmux.sv
module tb_oml_outmux;
    logic       clk = 1'b0;
    logic       rst;
    logic       sel_pin;
    logic       hold_low_n;
    logic [4:0] ext_in;
    logic [5:0] cfg_word;
    logic       prog_busy;
    logic       ctrl_wr;
    logic [1:0] ctrl_wdata;
    logic       slave_ack;
    logic [4:0] mux_pd;
    logic       solo_pd;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    oml_outmux dut (
        .clk(clk), .rst(rst), .sel_pin(sel_pin), .hold_low_n(hold_low_n),
        .ext_in(ext_in), .cfg_word(cfg_word), .prog_busy(prog_busy),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .slave_ack(slave_ack),
        .mux_pd(mux_pd), .solo_pd(solo_pd)
    );

    // {ctrl[1:0], sel, hold_n, cfg[5:0], ext[4:0]}
    localparam logic [14:0] VEC [10] = '{
        {2'b00, 1'b0, 1'b1, 6'b101100, 5'b00011},
        {2'b00, 1'b1, 1'b1, 6'b101100, 5'b00011},
        {2'b00, 1'b0, 1'b0, 6'b011111, 5'b10101},
        {2'b00, 1'b1, 1'b0, 6'b011111, 5'b10101},
        {2'b01, 1'b0, 1'b1, 6'b111000, 5'b01110},
        {2'b01, 1'b1, 1'b1, 6'b111000, 5'b01110},
        {2'b11, 1'b0, 1'b1, 6'b010011, 5'b11100},
        {2'b11, 1'b1, 1'b1, 6'b010011, 5'b11100},
        {2'b11, 1'b1, 1'b0, 6'b010011, 5'b11100},
        {2'b01, 1'b1, 1'b0, 6'b000001, 5'b00110}
    };

    // Expected pull-down enables from R2, R3, R5, R6, R8, R10
    function automatic logic [4:0] exp_pd(logic [1:0] c, logic s, logic h,
                                          logic [5:0] w, logic [4:0] e);
        logic from_word;
        from_word = c[0] ? c[1] : !s;
        return ~(from_word ? (h ? w[4:0] : 5'b0) : e);
    endfunction

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [1:0] v);
        @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_wr = 1'b0;
    endtask

    task automatic pulse_ack;
        @(negedge clk); slave_ack = 1'b1;
        @(negedge clk); slave_ack = 1'b0;
    endtask

    task automatic settle;
        repeat (3) @(posedge clk);
        #5;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; sel_pin = 1'b0; hold_low_n = 1'b1; ext_in = 5'b11001;
        cfg_word = 6'b101010; prog_busy = 1'b0; ctrl_wr = 1'b0;
        ctrl_wdata = 2'b00; slave_ack = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        settle;
        // R1 R2 R10: pin mode after reset, pin low -> stored word
        check("R1", mux_pd, 5'b10101);
        check("R2", {4'b0, solo_pd}, 5'b0);

        // Vector table
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            sel_pin    = VEC[k][12];
            hold_low_n = VEC[k][11];
            cfg_word   = VEC[k][10:5];
            ext_in     = VEC[k][4:0];
            wr_ctrl(VEC[k][14:13]);
            settle;
            check("R2/R3/R6/R8", mux_pd,
                  exp_pd(VEC[k][14:13], VEC[k][12], VEC[k][11], VEC[k][10:5], VEC[k][4:0]));
        end

        // R4: side latch follows while low, holds after pin rises
        wr_ctrl(2'b00);
        @(negedge clk); hold_low_n = 1'b1; sel_pin = 1'b0; cfg_word = 6'b100000;
        settle;
        check("R4 open", {4'b0, solo_pd}, 5'b0);
        @(negedge clk); sel_pin = 1'b1;
        settle;
        @(negedge clk); cfg_word = 6'b000000;
        settle;
        check("R4 held", {4'b0, solo_pd}, 5'b0);
        check("R3", mux_pd, ~ext_in);
        @(negedge clk); sel_pin = 1'b0;
        settle;
        check("R4 reopen", {4'b0, solo_pd}, 5'b1);

        // R5: register mode, pin has no effect
        @(negedge clk); cfg_word = 6'b001100; ext_in = 5'b10010;
        wr_ctrl(2'b01);
        settle;
        check("R5 pins", mux_pd, 5'b01101);
        @(negedge clk); sel_pin = 1'b1;
        settle;
        check("R5 pin ignored", mux_pd, 5'b01101);
        check("R5 side ignored", {4'b0, solo_pd}, 5'b1);

        // R7: acknowledge-timed capture
        @(negedge clk); sel_pin = 1'b0; cfg_word = 6'b100110;
        wr_ctrl(2'b11);
        settle;
        check("R7 before ack", {4'b0, solo_pd}, 5'b1);
        check("R6 word", mux_pd, 5'b11001);
        pulse_ack;
        settle;
        check("R7 after ack", {4'b0, solo_pd}, 5'b0);
        @(negedge clk); cfg_word = 6'b000110;
        pulse_ack;
        settle;
        check("R7 unarmed ack", {4'b0, solo_pd}, 5'b0);

        // R9: busy holds stored-word outputs
        wr_ctrl(2'b00);
        @(negedge clk); sel_pin = 1'b0; cfg_word = 6'b010101;
        settle;
        check("R9 before", mux_pd, 5'b01010);
        @(negedge clk); prog_busy = 1'b1; cfg_word = 6'b001010;
        settle;
        check("R9 held", mux_pd, 5'b01010);
        @(negedge clk); prog_busy = 1'b0;
        settle;
        check("R9 release", mux_pd, 5'b10101);

        // R8: force low only on stored-word source
        @(negedge clk); hold_low_n = 1'b0;
        settle;
        check("R8 word", mux_pd, 5'b11111);
        @(negedge clk); sel_pin = 1'b1; ext_in = 5'b00111;
        settle;
        check("R8 pins", mux_pd, 5'b11000);

        // R1: reset discards register mode
        @(negedge clk); hold_low_n = 1'b1; sel_pin = 1'b0;
        wr_ctrl(2'b11);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; sel_pin = 1'b1;
        settle;
        check("R1 pin mode", mux_pd, 5'b11000);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule